// File: doc/BRIEF.md
# Memory-Mapped Timer Register Frame

This block puts one free-running 64-bit system count and two compare timers behind a 32-bit register window of 0x40 bytes. A bus master reaches it through a plain request port made of valid, write, byte address and write data. Read data comes back one cycle after the request. The count advances by one on every clock cycle in which the tick-enable input is high.

The physical timer compares against the raw count. The virtual timer compares against the raw count plus a programmable 64-bit offset. Each timer can be programmed in two ways: as an absolute 64-bit compare value, or as a signed 32-bit distance from the current count. Each timer drives its own interrupt line. Every 64-bit quantity is split into a low word and a high word. Reading a low count word captures the matching high word, so a low-then-high read pair always returns one coherent 64-bit value.

Top module: `tmr_frame`

## Requirements
- R1: After reset the count, frequency, access, offset, compare and control registers are all zero. Both interrupt lines are low and `bus_rvalid` is low.
- R2: The count rises by exactly one on each clock edge where `tick_en` is high, and holds its value otherwise.
- R3: Byte offset 0x00 returns the low word of the physical count. Offset 0x08 returns the low word of the virtual count, which is the physical count plus the 64-bit offset, taken modulo 2^64.
- R4: A read of 0x00 captures the physical count's high word, and a read of 0x04 returns that captured word. A read of 0x08 captures the virtual count's high word, and a read of 0x0C returns that captured word. Later changes to the count or the offset do not alter a captured word.
- R5: Offset 0x10 is a 32-bit read/write frequency register. Offset 0x14 is an access register that stores bits [9:0] and reads zero in bits [31:10].
- R6: Offsets 0x18 and 0x1C are the read/write low and high words of the virtual offset.
- R7: The physical compare value is read/write at 0x20 (low word) and 0x24 (high word). The virtual compare value is read/write at 0x30 (low word) and 0x34 (high word).
- R8: The relative-value register sits at 0x28 for the physical timer and at 0x38 for the virtual timer. A read returns the low 32 bits of (compare minus that timer's count). A write sets the compare value to that timer's current count plus the sign-extended data word.
- R9: The control register sits at 0x2C for the physical timer and at 0x3C for the virtual timer. Bit 0 is enable and bit 1 is mask; both are read/write. Bit 2 is a read-only status bit, equal to enable AND (timer count >= compare value, unsigned). All other bits read zero.
- R10: `phys_irq` equals the physical timer's status AND NOT its mask, and `virt_irq` does the same for the virtual timer. Each line depends only on its own timer.
- R11: Writes to the count offsets 0x00 to 0x0C have no effect.
- R12: An address is unmapped if its bits [1:0] are not zero or if any bit at or above bit 6 is set. A read of an unmapped address returns zero, and a write to one changes nothing.
- R13: `bus_rvalid` is high in exactly the cycle after a read request, with `bus_rdata` valid in that cycle, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Count advance enable |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rvalid` is high |
| bus_rvalid | output | 1 | Read response strobe |
| phys_irq | output | 1 | Physical timer interrupt |
| virt_irq | output | 1 | Virtual timer interrupt |

## Verification
A count that skips or stalls shows up in the very next read of 0x00 or 0x08, and it also shifts the interrupt edge away from the tick on which the count meets the compare value. A stale or wrongly captured high word shows up only when the high half is read after its low half, so the bench changes the offset between those two reads. A wrong compare value, or a wrong status decision, reaches the interrupt pin combinationally in the same cycle. It is also visible through the relative-value and control reads that follow one cycle later.

// File: rtl/tmr_frame_pkg.sv
package tmr_frame_pkg;

  localparam int WORD_W = 32;

  // Word index decoded from byte-address bits [5:2].
  typedef enum logic [3:0] {
    OFS_PCNT_LO = 4'h0,
    OFS_PCNT_HI = 4'h1,
    OFS_VCNT_LO = 4'h2,
    OFS_VCNT_HI = 4'h3,
    OFS_FREQ    = 4'h4,
    OFS_ACCESS  = 4'h5,
    OFS_VOFF_LO = 4'h6,
    OFS_VOFF_HI = 4'h7,
    OFS_PCMP_LO = 4'h8,
    OFS_PCMP_HI = 4'h9,
    OFS_PREL    = 4'hA,
    OFS_PCTL    = 4'hB,
    OFS_VCMP_LO = 4'hC,
    OFS_VCMP_HI = 4'hD,
    OFS_VREL    = 4'hE,
    OFS_VCTL    = 4'hF
  } word_e;

  // Control word bit positions.
  localparam int CTL_EN   = 0;
  localparam int CTL_MASK = 1;
  localparam int CTL_STAT = 2;

endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
  import tmr_frame_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count,
  input  logic              wr_cmp_lo,
  input  logic              wr_cmp_hi,
  input  logic              wr_rel,
  input  logic              wr_ctl,
  input  logic [WORD_W-1:0] wdata,
  output logic [CNT_W-1:0]  cmp_val,
  output logic [WORD_W-1:0] rel_val,
  output logic [WORD_W-1:0] ctl_word,
  output logic              irq
);
  localparam int HI_W  = CNT_W - WORD_W;
  localparam int EXT_W = CNT_W - WORD_W;

  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic             en_q, en_d, mask_q, mask_d;
  logic             reached, status;
  logic [CNT_W-1:0] diff;

  always_comb begin
    cmp_d  = cmp_q;
    en_d   = en_q;
    mask_d = mask_q;
    if (wr_cmp_lo) cmp_d[WORD_W-1:0]     = wdata;
    if (wr_cmp_hi) cmp_d[CNT_W-1:WORD_W] = wdata[HI_W-1:0];
    if (wr_rel)    cmp_d = count + {{EXT_W{wdata[WORD_W-1]}}, wdata};
    if (wr_ctl) begin
      en_d   = wdata[CTL_EN];
      mask_d = wdata[CTL_MASK];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      en_q   <= en_d;
      mask_q <= mask_d;
    end
  end

  assign reached = (count >= cmp_q);
  assign status  = en_q && reached;
  assign diff    = cmp_q - count;

  always_comb begin
    ctl_word           = '0;
    ctl_word[CTL_EN]   = en_q;
    ctl_word[CTL_MASK] = mask_q;
    ctl_word[CTL_STAT] = status;
  end

  assign cmp_val = cmp_q;
  assign rel_val = diff[WORD_W-1:0];
  assign irq     = status && !mask_q;
endmodule

// File: rtl/tmr_frame.sv
module tmr_frame
  import tmr_frame_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 64,
  parameter int ACC_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              phys_irq,
  output logic              virt_irq
);
  localparam int N_TMR = 2;
  localparam int HI_W  = CNT_W - WORD_W;

  logic rst_i_n;

  tmr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Count and its virtual view
  logic [CNT_W-1:0] phys_cnt, virt_cnt;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .tick_en (tick_en),
    .count   (phys_cnt)
  );

  // Address decode
  word_e word;
  logic  mapped, rd_req, wr_req;

  assign word   = word_e'(bus_addr[5:2]);
  assign mapped = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:6] == '0);
  assign rd_req = bus_valid && !bus_write;
  assign wr_req = bus_valid && bus_write && mapped;

  // Frame registers
  logic [WORD_W-1:0] freq_q, freq_d;
  logic [ACC_W-1:0]  acc_q, acc_d;
  logic [CNT_W-1:0]  voff_q, voff_d;
  logic [HI_W-1:0]   psnap_q, psnap_d, vsnap_q, vsnap_d;
  logic [WORD_W-1:0] rdata_q, rdata_d;
  logic              rvalid_q, rvalid_d;

  assign virt_cnt = phys_cnt + voff_q;

  // Timers
  logic [CNT_W-1:0]  t_cnt [N_TMR];
  logic [CNT_W-1:0]  t_cmp [N_TMR];
  logic [WORD_W-1:0] t_rel [N_TMR];
  logic [WORD_W-1:0] t_ctl [N_TMR];
  logic [N_TMR-1:0]  t_wlo, t_whi, t_wrel, t_wctl, t_irq;

  for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
    localparam logic [3:0] BASE = 4'(8 + 4 * gi);

    if (gi == 0) begin : g_phys
      assign t_cnt[gi] = phys_cnt;
    end else begin : g_virt
      assign t_cnt[gi] = virt_cnt;
    end

    assign t_wlo[gi]  = wr_req && (word == word_e'(BASE));
    assign t_whi[gi]  = wr_req && (word == word_e'(BASE + 4'd1));
    assign t_wrel[gi] = wr_req && (word == word_e'(BASE + 4'd2));
    assign t_wctl[gi] = wr_req && (word == word_e'(BASE + 4'd3));

    tmr_compare #(.CNT_W(CNT_W)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_i_n),
      .count     (t_cnt[gi]),
      .wr_cmp_lo (t_wlo[gi]),
      .wr_cmp_hi (t_whi[gi]),
      .wr_rel    (t_wrel[gi]),
      .wr_ctl    (t_wctl[gi]),
      .wdata     (bus_wdata),
      .cmp_val   (t_cmp[gi]),
      .rel_val   (t_rel[gi]),
      .ctl_word  (t_ctl[gi]),
      .irq       (t_irq[gi])
    );
  end

  // Register write next-state
  always_comb begin
    freq_d = freq_q;
    acc_d  = acc_q;
    voff_d = voff_q;
    if (wr_req) begin
      unique case (word)
        OFS_FREQ:    freq_d = bus_wdata;
        OFS_ACCESS:  acc_d  = bus_wdata[ACC_W-1:0];
        OFS_VOFF_LO: voff_d[WORD_W-1:0]     = bus_wdata;
        OFS_VOFF_HI: voff_d[CNT_W-1:WORD_W] = bus_wdata[HI_W-1:0];
        default: ;
      endcase
    end
  end

  // Read path
  logic [WORD_W-1:0] rd_sel;

  always_comb begin
    rd_sel = '0;
    unique case (word)
      OFS_PCNT_LO: rd_sel = phys_cnt[WORD_W-1:0];
      OFS_PCNT_HI: rd_sel = WORD_W'(psnap_q);
      OFS_VCNT_LO: rd_sel = virt_cnt[WORD_W-1:0];
      OFS_VCNT_HI: rd_sel = WORD_W'(vsnap_q);
      OFS_FREQ:    rd_sel = freq_q;
      OFS_ACCESS:  rd_sel = WORD_W'(acc_q);
      OFS_VOFF_LO: rd_sel = voff_q[WORD_W-1:0];
      OFS_VOFF_HI: rd_sel = WORD_W'(voff_q[CNT_W-1:WORD_W]);
      OFS_PCMP_LO: rd_sel = t_cmp[0][WORD_W-1:0];
      OFS_PCMP_HI: rd_sel = WORD_W'(t_cmp[0][CNT_W-1:WORD_W]);
      OFS_PREL:    rd_sel = t_rel[0];
      OFS_PCTL:    rd_sel = t_ctl[0];
      OFS_VCMP_LO: rd_sel = t_cmp[1][WORD_W-1:0];
      OFS_VCMP_HI: rd_sel = WORD_W'(t_cmp[1][CNT_W-1:WORD_W]);
      OFS_VREL:    rd_sel = t_rel[1];
      OFS_VCTL:    rd_sel = t_ctl[1];
      default:     rd_sel = '0;
    endcase
  end

  always_comb begin
    psnap_d  = psnap_q;
    vsnap_d  = vsnap_q;
    rdata_d  = '0;
    rvalid_d = rd_req;
    if (rd_req && mapped) begin
      rdata_d = rd_sel;
      if (word == OFS_PCNT_LO) psnap_d = phys_cnt[CNT_W-1:WORD_W];
      if (word == OFS_VCNT_LO) vsnap_d = virt_cnt[CNT_W-1:WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      freq_q   <= '0;
      acc_q    <= '0;
      voff_q   <= '0;
      psnap_q  <= '0;
      vsnap_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      freq_q   <= freq_d;
      acc_q    <= acc_d;
      voff_q   <= voff_d;
      psnap_q  <= psnap_d;
      vsnap_q  <= vsnap_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;
  assign phys_irq   = t_irq[0];
  assign virt_irq   = t_irq[1];
endmodule

// File: rtl/tmr_frame_chk.sv
module tmr_frame_chk #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              phys_irq,
  input logic              virt_irq,
  input logic [CNT_W-1:0]  phys_cnt,
  input logic [31:0]       freq_q,
  input logic [31:0]       pctl,
  input logic [31:0]       vctl
);
  logic unmapped;
  assign unmapped = (bus_addr[1:0] != 2'b00) || (bus_addr[ADDR_W-1:6] != '0);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (phys_cnt - $past(phys_cnt)) == CNT_W'(1));

  assert_count_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(phys_cnt));

  assert_rvalid_after_read_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |=> bus_rvalid);

  assert_rvalid_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> !bus_rvalid);

  assert_unmapped_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && unmapped) |=> bus_rdata == 32'h0);

  assert_unmapped_write_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && unmapped) |=> $stable(freq_q));

  assert_phys_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    phys_irq |-> (pctl[0] && !pctl[1] && pctl[2]));

  assert_virt_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    virt_irq |-> (vctl[0] && !vctl[1] && vctl[2]));
endmodule

bind tmr_frame tmr_frame_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_i_n),
  .tick_en    (tick_en),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .phys_irq   (phys_irq),
  .virt_irq   (virt_irq),
  .phys_cnt   (phys_cnt),
  .freq_q     (freq_q),
  .pctl       (t_ctl[0]),
  .vctl       (t_ctl[1])
);

// File: tb/tmr_frame_test.sv
module tmr_frame_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en;
  logic        bus_valid;
  logic        bus_write;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        phys_irq;
  logic        virt_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  longint unsigned pc = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  tmr_frame uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .phys_irq(phys_irq), .virt_irq(virt_irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // Monitor: pops expected read data as responses appear.
  always @(negedge clk) begin
    if (bus_rvalid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check("R13 unexpected response", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
    pc += longint'(n);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    check("R1 rvalid in reset", {31'd0, bus_rvalid}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 phys_irq", {31'd0, phys_irq}, 32'd0);
    check("R1 virt_irq", {31'd0, virt_irq}, 32'd0);
    check("R13 rvalid idle", {31'd0, bus_rvalid}, 32'd0);
    rd(12'h00, 32'h0, "R1 count lo");
    rd(12'h10, 32'h0, "R1 freq");
    rd(12'h2C, 32'h0, "R1 phys ctl");
    rd(12'h3C, 32'h0, "R1 virt ctl");
    rd(12'h18, 32'h0, "R1 voff lo");

    // R2/R3 counting
    ticks(37);
    rd(12'h00, 32'(pc), "R2 R3 phys count lo");
    rd(12'h04, 32'h0, "R4 phys count hi");
    rd(12'h08, 32'(pc), "R3 virt count with zero offset");

    // R11 count words read-only
    wr(12'h00, 32'hDEAD_0000);
    wr(12'h04, 32'h0000_BEEF);
    wr(12'h08, 32'h1234_5678);
    rd(12'h00, 32'(pc), "R11 phys count after write");
    rd(12'h04, 32'h0, "R11 phys hi after write");

    // R5 frequency and access
    wr(12'h10, 32'h0BEB_C200);
    rd(12'h10, 32'h0BEB_C200, "R5 freq");
    wr(12'h14, 32'hFFFF_FFFF);
    rd(12'h14, 32'h0000_03FF, "R5 access width");

    // R6 offset, R3 virtual view, R4 snapshot
    wr(12'h18, 32'hFFFF_FFF0);
    wr(12'h1C, 32'h0000_0005);
    rd(12'h18, 32'hFFFF_FFF0, "R6 voff lo");
    rd(12'h1C, 32'h0000_0005, "R6 voff hi");
    rd(12'h08, 32'h0000_0015, "R3 virt lo with carry");
    wr(12'h1C, 32'h0000_0009);
    rd(12'h0C, 32'h0000_0006, "R4 virt hi snapshot held");
    rd(12'h08, 32'h0000_0015, "R3 virt lo again");
    rd(12'h0C, 32'h0000_000A, "R4 virt hi new snapshot");
    wr(12'h1C, 32'h0);
    wr(12'h18, 32'h0000_0100);

    // R9/R10 control with compare zero
    wr(12'h2C, 32'h1);
    check("R10 phys irq enabled at compare 0", {31'd0, phys_irq}, 32'd1);
    rd(12'h2C, 32'h5, "R9 ctl status set");
    wr(12'h2C, 32'h3);
    check("R10 mask gates irq", {31'd0, phys_irq}, 32'd0);
    rd(12'h2C, 32'h7, "R9 ctl masked");
    wr(12'h2C, 32'h4);
    rd(12'h2C, 32'h0, "R9 status bit read-only");

    // R8 relative write, R7 readback, firing edge
    wr(12'h28, 32'd100);
    rd(12'h20, 32'(pc + 100), "R8 R7 compare lo from relative");
    rd(12'h24, 32'h0, "R7 compare hi");
    rd(12'h28, 32'd100, "R8 relative read");
    wr(12'h2C, 32'h1);
    check("R10 phys irq before", {31'd0, phys_irq}, 32'd0);
    ticks(99);
    check("R10 phys irq one short", {31'd0, phys_irq}, 32'd0);
    rd(12'h28, 32'd1, "R8 relative one left");
    ticks(1);
    check("R10 phys irq at compare", {31'd0, phys_irq}, 32'd1);
    rd(12'h28, 32'd0, "R8 relative zero");
    rd(12'h2C, 32'h5, "R9 status at compare");

    // R8 negative relative write
    wr(12'h28, 32'hFFFF_FFF6);
    rd(12'h20, 32'(pc - 10), "R8 negative relative");
    rd(12'h28, 32'hFFFF_FFF6, "R8 negative readback");
    check("R10 phys irq past compare", {31'd0, phys_irq}, 32'd1);

    // Virtual timer uses count plus offset (0x100)
    wr(12'h34, 32'h0);
    wr(12'h30, 32'd400);
    wr(12'h3C, 32'h1);
    check("R10 virt irq below", {31'd0, virt_irq}, 32'd0);
    check("R10 phys irq independent", {31'd0, phys_irq}, 32'd1);
    ticks(int'(400 - 256 - pc - 1));
    check("R9 virt one short", {31'd0, virt_irq}, 32'd0);
    ticks(1);
    check("R9 virt reaches compare", {31'd0, virt_irq}, 32'd1);
    rd(12'h38, 32'd0, "R8 virt relative zero");
    rd(12'h3C, 32'h5, "R9 virt ctl");
    wr(12'h38, 32'd50);
    check("R8 virt relative rearm", {31'd0, virt_irq}, 32'd0);
    rd(12'h30, 32'd450, "R8 R7 virt compare from relative");

    // R7 compare high word
    wr(12'h24, 32'h1);
    check("R7 phys hi moves compare", {31'd0, phys_irq}, 32'd0);
    rd(12'h24, 32'h1, "R7 phys compare hi");
    rd(12'h2C, 32'h1, "R9 status clear after hi write");

    // R12 unmapped
    rd(12'h40, 32'h0, "R12 unmapped high read");
    rd(12'h11, 32'h0, "R12 misaligned read");
    wr(12'h50, 32'h1234_5678);
    wr(12'h11, 32'h8765_4321);
    wr(12'h55, 32'h0000_0000);
    rd(12'h10, 32'h0BEB_C200, "R12 freq untouched");
    rd(12'h14, 32'h0000_03FF, "R12 access untouched");

    repeat (3) @(negedge clk);
    check("R13 responses drained", exp_q.size(), 32'd0);
    check("R13 rvalid idle at end", {31'd0, bus_rvalid}, 32'd0);
    finish_up();
  end
endmodule